// File: doc/BRIEF.md
# Eight-channel PWM timer bank

The block holds eight independent PWM timers behind a simple 32-bit register bus. Each timer has a free-running 32-bit counter, a duty compare, a period compare and a control word. Together these produce one pulse output per channel with fixed inverted polarity: the pin is low while the counter is below the duty value and high for the rest of the period. Software programs the compare values while the channel is off, then sets the enable and output-enable bits.

The register space is split into two windows. Channels 0 to 3 use 16-byte slots from the base, and channels 4 to 7 repeat the same layout with address bit 15 set. Each channel can run one period only (single-shot mode). At the end of every period it sets a sticky flag, which can be routed to a per-channel interrupt line. The external-clock, edge-select and capture bits are stored and read back but have no effect on counting. Reads are combinational from the address, so read data is valid in the same cycle.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every counter, compare and control register reads 0. Every pwm_o bit is 1, and every pwm_oe_o and irq_o bit is 0.
- R2: Channel c decodes at byte address (c/4)*0x8000 + (c%4)*0x10. Within a slot, 0x0 is the counter, 0x4 the duty, 0x8 the period and 0xC the control word. An address with any of bits 14:6 or 1:0 set hits no register: a read returns 0 and a write changes nothing.
- R3: The control word keeps bits 8:0 as written. The layout is: bit0 enable, bit1 external clock select, bit2 edge select, bit3 output enable, bit4 single-shot, bit5 interrupt enable, bit6 flag, bit7 counter clear, bit8 capture enable. Bits 31:9 read 0. Bit 6 is not stored from the write data (see R9).
- R4: The counter advances by one per clock only while enable is 1. While enable is 0 it holds its value.
- R5: With period P, the counter runs 0..P-1 and then wraps to 0, so one period lasts P cycles. On each wrap the flag is set.
- R6: pwm_o of an enabled channel is 0 while counter < duty and 1 otherwise. A disabled channel outputs 1. Duty 0 gives a constant 1, and duty >= period gives a constant 0.
- R7: pwm_oe_o follows control bit3, whatever the enable bit is. When it is 0, the pad is released.
- R8: When single-shot is set, the channel clears its own enable bit at the end of the first period. The counter is left at 0 and the output returns to 1.
- R9: irq_o is the flag ANDed with interrupt enable. Writing 1 to bit6 clears the flag, and writing 0 leaves it unchanged. If a period ends in the same cycle as a clear, the set wins.
- R10: While counter clear (bit7) is 1, the counter reads 0, even if software writes the counter.
- R11: Software can write the counter at offset 0x0 and read it back.
- R12: Duty and period accept writes while the channel is disabled and read back exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, same cycle |
| pwm_o | output | 8 | Inverted-polarity pulse outputs |
| pwm_oe_o | output | 8 | Output enable per pin |
| irq_o | output | 8 | Per-channel interrupt lines |

## Verification
A wrong counter shows up on pwm_o within one period: the low phase has the wrong length, or it drifts against a cycle-exact model of count, compare and wrap. A lost or stale control bit appears directly in a read-back of the control word. A decode fault shows up as data written to one slot turning up in another channel, or at an address that must miss. A flag or single-shot fault shows up on irq_o or on the enable bit in the control word one cycle after the period ends.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
  typedef enum logic [1:0] {
    REG_CNT    = 2'd0,
    REG_DUTY   = 2'd1,
    REG_PERIOD = 2'd2,
    REG_CTRL   = 2'd3
  } reg_sel_e;

  localparam int CTRL_W    = 9;
  localparam int B_EN      = 0;
  localparam int B_EXTCLK  = 1;
  localparam int B_NEGEDGE = 2;
  localparam int B_OE      = 3;
  localparam int B_ONESHOT = 4;
  localparam int B_IE      = 5;
  localparam int B_FLAG    = 6;
  localparam int B_CNTCLR  = 7;
  localparam int B_CAPT    = 8;

  localparam int REG_LSB   = 2;
  localparam int SLOT_LSB  = 4;
endpackage

// File: rtl/pwm_bank_dec.sv
`timescale 1ns/1ps
module pwm_bank_dec
  import pwm_bank_pkg::*;
#(
  parameter int SLOT_W  = 2,
  parameter int WIN_LSB = 15,
  parameter int WIN_W   = 1,
  localparam int AW     = WIN_LSB + WIN_W,
  localparam int CH_W   = WIN_W + SLOT_W
) (
  input  logic [AW-1:0]   addr_i,
  output logic            hit_o,
  output logic [CH_W-1:0] ch_o,
  output reg_sel_e        reg_o
);
  localparam int GAP_LSB = SLOT_LSB + SLOT_W;

  assign reg_o = reg_sel_e'(addr_i[REG_LSB +: 2]);
  assign ch_o  = {addr_i[WIN_LSB +: WIN_W], addr_i[SLOT_LSB +: SLOT_W]};
  assign hit_o = (addr_i[1:0] == 2'b00) && (addr_i[WIN_LSB-1:GAP_LSB] == '0);
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  reg_sel_e      reg_sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pwm_o,
  output logic          oe_o,
  output logic          irq_o
);
  logic [DW-1:0]     cnt_q, duty_q, period_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              wr_cnt, wr_duty, wr_period, wr_ctrl;
  logic              en, clr, wrap, period_end, active;

  assign wr_cnt    = we_i && (reg_sel_i == REG_CNT);
  assign wr_duty   = we_i && (reg_sel_i == REG_DUTY);
  assign wr_period = we_i && (reg_sel_i == REG_PERIOD);
  assign wr_ctrl   = we_i && (reg_sel_i == REG_CTRL);

  assign en  = ctrl_q[B_EN];
  assign clr = ctrl_q[B_CNTCLR];
  // compare one bit wider so an all-ones counter cannot overflow past the period
  assign wrap       = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_q};
  assign period_end = en && !clr && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wdata_i;
    end else if (en) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      period_q <= '0;
    end else begin
      if (wr_duty)   duty_q   <= wdata_i;
      if (wr_period) period_q <= wdata_i;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d         = wdata_i[CTRL_W-1:0];
      ctrl_d[B_FLAG] = (ctrl_q[B_FLAG] & ~wdata_i[B_FLAG]) | period_end;
    end else if (period_end) begin
      ctrl_d[B_FLAG] = 1'b1;
      if (ctrl_q[B_ONESHOT]) ctrl_d[B_EN] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign active = en && (cnt_q < duty_q);
  assign pwm_o  = ~active;
  assign oe_o   = ctrl_q[B_OE];
  assign irq_o  = ctrl_q[B_FLAG] & ctrl_q[B_IE];

  always_comb begin
    unique case (reg_sel_i)
      REG_CNT:    rdata_o = cnt_q;
      REG_DUTY:   rdata_o = duty_q;
      REG_PERIOD: rdata_o = period_q;
      default:    rdata_o = DW'(ctrl_q);
    endcase
  end

  a_r10_clear_holds_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (cnt_q == '0));
  a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !clr && !wr_cnt) |=> $stable(cnt_q));
  a_r8_oneshot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end && ctrl_q[B_ONESHOT] && !wr_ctrl) |=> !ctrl_q[B_EN]);
  a_r5_flag_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end |=> ctrl_q[B_FLAG]);
  a_r6_duty_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == '0) |-> pwm_o);
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int DW         = 32,
  parameter int CH_PER_WIN = 4,
  parameter int NUM_WIN    = 2,
  parameter int WIN_LSB    = 15,
  localparam int NUM_CH    = CH_PER_WIN * NUM_WIN,
  localparam int SLOT_W    = $clog2(CH_PER_WIN),
  localparam int WIN_W     = $clog2(NUM_WIN),
  localparam int AW        = WIN_LSB + WIN_W,
  localparam int CH_W      = SLOT_W + WIN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] pwm_oe_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic            hit;
  logic [CH_W-1:0] ch_idx;
  reg_sel_e        reg_sel;
  logic [NUM_CH-1:0] ch_we;
  logic [DW-1:0]   ch_rdata [NUM_CH];

  pwm_bank_dec #(
    .SLOT_W (SLOT_W),
    .WIN_LSB(WIN_LSB),
    .WIN_W  (WIN_W)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit),
    .ch_o  (ch_idx),
    .reg_o (reg_sel)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_we[i] = req_i && we_i && hit && (ch_idx == CH_W'(i));

    pwm_chan #(.DW(DW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (ch_we[i]),
      .reg_sel_i(reg_sel),
      .wdata_i  (wdata_i),
      .rdata_o  (ch_rdata[i]),
      .pwm_o    (pwm_o[i]),
      .oe_o     (pwm_oe_o[i]),
      .irq_o    (irq_o[i])
    );
  end

  assign rdata_o = hit ? ch_rdata[ch_idx] : '0;

  a_r2_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_we));
  a_r2_miss_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (ch_we == '0));
endmodule

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pwm, oe, irq;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pwm_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm), .pwm_oe_o(oe), .irq_o(irq)
  );

  // {we, addr, data}; for reads data is the expected value
  localparam int NV = 21;
  localparam logic [48:0] VEC [NV] = '{
    {1'b1, 16'h0004, 32'hA000_0001},
    {1'b1, 16'h0014, 32'hA000_0011},
    {1'b1, 16'h0024, 32'hA000_0021},
    {1'b1, 16'h0034, 32'hA000_0031},
    {1'b1, 16'h8004, 32'hA000_0041},
    {1'b1, 16'h8014, 32'hA000_0051},
    {1'b1, 16'h8024, 32'hA000_0061},
    {1'b1, 16'h8034, 32'hA000_0071},
    {1'b1, 16'h8038, 32'hFFFF_FFFF},
    {1'b1, 16'h801C, 32'h0000_01FE},
    {1'b1, 16'h802C, 32'hFFFF_FE3C},
    {1'b0, 16'h0004, 32'hA000_0001},
    {1'b0, 16'h0034, 32'hA000_0031},
    {1'b0, 16'h8004, 32'hA000_0041},
    {1'b0, 16'h8034, 32'hA000_0071},
    {1'b0, 16'h8038, 32'hFFFF_FFFF},
    {1'b0, 16'h801C, 32'h0000_01BE},
    {1'b0, 16'h802C, 32'h0000_003C},
    {1'b0, 16'h0024, 32'hA000_0021},
    {1'b0, 16'h8014, 32'hA000_0051},
    {1'b0, 16'h0008, 32'h0000_0000}
  };

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req_s, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    chk("R1 pwm", {24'h0, pwm}, 32'hFF);
    chk("R1 oe", {24'h0, oe}, 32'h0);
    chk("R1 irq", {24'h0, irq}, 32'h0);
    bus_rd(16'h803C, v); chk("R1 ctrl7", v, 32'h0);
    bus_rd(16'h0018, v); chk("R1 period1", v, 32'h0);

    // R2 R3 R12 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][48]) bus_wr(VEC[i][47:32], VEC[i][31:0]);
      else begin
        bus_rd(VEC[i][47:32], v);
        chk($sformatf("R2/R12/R3 vec%0d", i), v, VEC[i][31:0]);
      end
    end

    // R2 misses
    bus_wr(16'h0044, 32'hDEAD_BEEF);
    bus_wr(16'h4004, 32'h1234_5678);
    bus_wr(16'h0006, 32'h0BAD_0BAD);
    bus_rd(16'h0044, v); chk("R2 miss read", v, 32'h0);
    bus_rd(16'h0004, v); chk("R2 miss no write", v, 32'hA000_0001);

    // R5 R6 timing: period 4, duty 2
    bus_wr(16'h0004, 32'd2);
    bus_wr(16'h0008, 32'd4);
    bus_wr(16'h0000, 32'd0);
    bus_wr(16'h000C, 32'h9);
    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R6 R5 wave k%0d", k), {31'h0, pwm[0]}, ((k % 4) < 2) ? 32'h0 : 32'h1);
      @(negedge clk);
    end
    bus_rd(16'h000C, v); chk("R5 flag set", v & 32'h40, 32'h40);
    chk("R9 irq masked", {31'h0, irq[0]}, 32'h0);

    // R9 flag and mask
    bus_wr(16'h000C, 32'h20);
    chk("R9 irq on", {31'h0, irq[0]}, 32'h1);
    bus_rd(16'h000C, v); chk("R9 write0 keeps flag", v, 32'h60);
    bus_wr(16'h000C, 32'h60);
    chk("R9 irq cleared", {31'h0, irq[0]}, 32'h0);
    bus_rd(16'h000C, v); chk("R9 w1c", v, 32'h20);

    // R4 hold while disabled
    bus_rd(16'h0000, v);
    repeat (5) @(negedge clk);
    bus_rd(16'h0000, v2); chk("R4 hold", v2, v);
    chk("R6 disabled idle", {31'h0, pwm[0]}, 32'h1);

    // R11 counter write
    bus_wr(16'h0000, 32'h0000_1234);
    bus_rd(16'h0000, v); chk("R11 cnt write", v, 32'h1234);

    // R10 counter clear on ch3
    bus_wr(16'h0038, 32'd100);
    bus_wr(16'h003C, 32'h81);
    repeat (3) @(negedge clk);
    bus_rd(16'h0030, v); chk("R10 held", v, 32'h0);
    bus_wr(16'h0030, 32'h55);
    bus_rd(16'h0030, v); chk("R10 write blocked", v, 32'h0);
    bus_wr(16'h003C, 32'h01);
    repeat (3) @(negedge clk);
    bus_rd(16'h0030, v); chk("R4 R10 counts after release", v, 32'd3);

    // R6 duty 0 and duty == period on ch1
    bus_wr(16'h0014, 32'd0);
    bus_wr(16'h0018, 32'd5);
    bus_wr(16'h001C, 32'h9);
    v = 32'h1;
    for (int k = 0; k < 10; k++) begin
      v &= {31'h0, pwm[1]};
      @(negedge clk);
    end
    chk("R6 duty0 idle", v, 32'h1);
    bus_wr(16'h001C, 32'h0);
    bus_wr(16'h0014, 32'd5);
    bus_wr(16'h001C, 32'h9);
    v = 32'h0;
    for (int k = 0; k < 10; k++) begin
      v |= {31'h0, pwm[1]};
      @(negedge clk);
    end
    chk("R6 duty>=period active", v, 32'h0);

    // R7 output enable on ch2
    bus_wr(16'h002C, 32'h1);
    chk("R7 oe off", {31'h0, oe[2]}, 32'h0);
    bus_wr(16'h002C, 32'h9);
    chk("R7 oe on", {31'h0, oe[2]}, 32'h1);
    bus_wr(16'h002C, 32'h8);
    chk("R7 oe without en", {31'h0, oe[2]}, 32'h1);
    chk("R6 idle with oe", {31'h0, pwm[2]}, 32'h1);

    // R8 single-shot on ch4: period 3, duty 1
    bus_wr(16'h8004, 32'd1);
    bus_wr(16'h8008, 32'd3);
    bus_wr(16'h8000, 32'd0);
    bus_wr(16'h800C, 32'h19);
    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R8 wave k%0d", k), {31'h0, pwm[4]}, (k == 0) ? 32'h0 : 32'h1);
      @(negedge clk);
    end
    bus_rd(16'h800C, v); chk("R8 enable cleared", v, 32'h58);
    bus_rd(16'h8000, v); chk("R8 counter parked", v, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule